// File: doc/BRIEF.md
# Clustered Thread-Rank Memory Request Arbiter

This block chooses one memory request per cycle out of a request buffer shared by several hardware threads. Thread priority is not fixed. For every thread the block counts cache misses and bandwidth use across a quantum. At the end of each quantum it orders the threads from least to most miss-intensive. The lightest threads form a low-intensity group for as long as their running share of bandwidth stays within a programmable fraction of the total. Every remaining thread goes into a high-intensity group.

Each low-intensity thread outranks each high-intensity thread. Within the high-intensity group the rank order rotates by one place every shuffle interval, so that no heavy thread keeps the last place for a whole quantum. Buffered requests are compared on the rank of their thread first. A row-buffer hit then wins over a miss, and after that an older request wins over a younger one. A tie on all three criteria goes to the lowest buffer index. DRAM command timing is not part of this block.

Top module: `thread_cluster_arbiter`

## Requirements
- R1: At each quantum end, threads are ordered by miss count, smallest first. Equal counts are ordered by lower thread index. A thread's new rank is its place in that order, and rank 0 is the highest priority.
- R2: Going through that order, a thread joins the low-intensity group while 64 × (cumulative bandwidth count up to and including it) ≤ alpha_i × (total bandwidth count). alpha_i is in units of 1/64. All later threads are high-intensity. Bit i of cluster_hi_o is 1 when thread i is high-intensity.
- R3: A quantum lasts QUANTUM_LEN cycles after reset release. New ranks and groups appear on the outputs right after the QUANTUM_LEN-th rising edge and are built only from counts of the quantum just ended. Both counters of every thread restart from zero.
- R4: Every low-intensity thread holds a smaller rank than every high-intensity thread. The ranks always form a permutation of 0..N_THREADS-1.
- R5: Every SHUFFLE_LEN cycles inside a quantum, the best-ranked high-intensity thread moves to rank N_THREADS-1 and each other high-intensity thread moves up one rank. Low-intensity ranks and group membership stay unchanged.
- R6: Among valid entries, the entry whose thread (req_tid_i field e at bits [e*TID_W +: TID_W]) has the smallest rank is granted, whatever its row-hit flag or age.
- R7: Among valid entries of equal thread rank, an entry with req_row_hit_i = 1 (row hit) beats one with 0.
- R8: Among valid entries equal on rank and row-hit flag, the larger req_age_i value (older) wins.
- R9: Among entries equal on all three criteria the lowest index is granted. An entry with req_valid_i = 0 is never granted, however good its fields.
- R10: With no valid entry, grant_valid_o is 0 and grant_idx_o is 0.
- R11: After reset thread i holds rank i and all threads are low-intensity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alpha_i | input | 6 | Low-group bandwidth share in 1/64 units, sampled at quantum end |
| miss_inc_i | input | N_THREADS | Per-thread miss count increment |
| bw_inc_i | input | N_THREADS | Per-thread bandwidth count increment |
| req_valid_i | input | N_ENTRIES | Buffer entry valid |
| req_tid_i | input | N_ENTRIES*TID_W | Thread index per entry |
| req_row_hit_i | input | N_ENTRIES | Entry targets the open row |
| req_age_i | input | N_ENTRIES*AGE_W | Entry age, larger is older |
| grant_valid_o | output | 1 | A request is granted |
| grant_idx_o | output | IDX_W | Index of the granted entry |
| thread_rank_o | output | N_THREADS*TID_W | Current rank per thread, 0 is best |
| cluster_hi_o | output | N_THREADS | High-intensity group membership |

## Verification
The bench sets up a quantum in which two light threads fall inside a 6/64 share and two heavy ones fall outside it. It checks that the groups are not published one cycle early, since a design with an off-by-one quantum counter would do that. It follows two rotations of the heavy group with a request pair whose winner flips on each rotation, which catches a rotation that moves the wrong way or disturbs light threads. A quantum with no activity must bring back the identity ranks; a counter that failed to clear would keep stale groups. A zero alpha with tied miss counts exercises index tie-breaking and zero-bandwidth threads staying light. The picker cases aim at rank outranking a row hit, a row hit outranking age, full ties, and a strong but invalid entry, where a wrong key order or a missing valid mask grants the wrong index.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  // alpha resolution: share counted in 1/2**ALPHA_W of total bandwidth
  localparam int unsigned ALPHA_W = 6;
endpackage

// File: rtl/tcm_thread_counter.sv
module tcm_thread_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= CNT_W'(inc_i);
    else if (inc_i && (cnt_q != '1))   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q <= CNT_W'(1)));
endmodule

// File: rtl/tcm_epoch_timer.sv
module tcm_epoch_timer #(
  parameter int unsigned QUANTUM_LEN = 64,
  parameter int unsigned SHUFFLE_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic quantum_end_o,
  output logic shuffle_o
);
  localparam int unsigned QW = (QUANTUM_LEN > 1) ? $clog2(QUANTUM_LEN) : 1;
  localparam int unsigned SW = (SHUFFLE_LEN > 1) ? $clog2(SHUFFLE_LEN) : 1;

  logic [QW-1:0] q_cnt;
  logic [SW-1:0] s_cnt;
  logic          s_wrap;

  assign quantum_end_o = (q_cnt == QW'(QUANTUM_LEN - 1));
  assign s_wrap        = (s_cnt == SW'(SHUFFLE_LEN - 1));
  assign shuffle_o     = s_wrap && !quantum_end_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_cnt <= '0;
      s_cnt <= '0;
    end else begin
      q_cnt <= quantum_end_o ? '0 : q_cnt + 1'b1;
      s_cnt <= (quantum_end_o || s_wrap) ? '0 : s_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tcm_rank_table.sv
module tcm_rank_table
  import tcm_pkg::*;
#(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TID_W     = 2,
  parameter int unsigned NLO_W     = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ALPHA_W-1:0]  alpha_i,
  input  logic [CNT_W-1:0]    miss_cnt_i [N_THREADS],
  input  logic [CNT_W-1:0]    bw_cnt_i   [N_THREADS],
  input  logic                quantum_end_i,
  input  logic                shuffle_i,
  output logic [TID_W-1:0]    rank_o     [N_THREADS],
  output logic [N_THREADS-1:0] hi_o
);
  localparam int unsigned SUM_W  = CNT_W + NLO_W;
  localparam int unsigned PROD_W = SUM_W + ALPHA_W;

  logic [TID_W-1:0]     pos     [N_THREADS];
  logic [SUM_W-1:0]     cum     [N_THREADS];
  logic [SUM_W-1:0]     total;
  logic [PROD_W-1:0]    limit;
  logic [N_THREADS-1:0] lo_new;
  logic [NLO_W-1:0]     nlo_new;

  logic [TID_W-1:0]     rank_q  [N_THREADS];
  logic [N_THREADS-1:0] hi_q;
  logic [NLO_W-1:0]     nlo_q;

  // order by miss count, ties to lower index
  always_comb begin
    for (int i = 0; i < N_THREADS; i++) begin
      pos[i] = '0;
      for (int j = 0; j < N_THREADS; j++) begin
        if (j != i && ((miss_cnt_i[j] < miss_cnt_i[i]) ||
                       (miss_cnt_i[j] == miss_cnt_i[i] && j < i)))
          pos[i] = pos[i] + 1'b1;
      end
    end
  end

  // running bandwidth in that order against alpha share of total
  always_comb begin
    total = '0;
    for (int i = 0; i < N_THREADS; i++) total = total + SUM_W'(bw_cnt_i[i]);
    limit = PROD_W'(alpha_i) * PROD_W'(total);
    nlo_new = '0;
    for (int i = 0; i < N_THREADS; i++) begin
      cum[i] = '0;
      for (int j = 0; j < N_THREADS; j++)
        if (pos[j] <= pos[i]) cum[i] = cum[i] + SUM_W'(bw_cnt_i[j]);
      lo_new[i] = ({cum[i], {ALPHA_W{1'b0}}} <= limit);
      nlo_new   = nlo_new + NLO_W'(lo_new[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_THREADS; i++) rank_q[i] <= TID_W'(i);
      hi_q  <= '0;
      nlo_q <= NLO_W'(N_THREADS);
    end else if (quantum_end_i) begin
      for (int i = 0; i < N_THREADS; i++) rank_q[i] <= pos[i];
      hi_q  <= ~lo_new;
      nlo_q <= nlo_new;
    end else if (shuffle_i && (nlo_q < NLO_W'(N_THREADS))) begin
      // rotate intensive ranks: top one drops to last place
      for (int i = 0; i < N_THREADS; i++) begin
        if (hi_q[i])
          rank_q[i] <= (NLO_W'(rank_q[i]) == nlo_q) ? TID_W'(N_THREADS - 1)
                                                     : rank_q[i] - 1'b1;
      end
    end
  end

  assign rank_o = rank_q;
  assign hi_o   = hi_q;

  logic [N_THREADS-1:0] seen;
  logic                 order_ok;
  always_comb begin
    seen     = '0;
    order_ok = 1'b1;
    for (int i = 0; i < N_THREADS; i++) begin
      if (32'(rank_q[i]) < N_THREADS) seen[rank_q[i]] = 1'b1;
      for (int j = 0; j < N_THREADS; j++)
        if (!hi_q[i] && hi_q[j] && !(rank_q[i] < rank_q[j])) order_ok = 1'b0;
    end
  end

  // R4
  rank_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) &seen);
  // R4
  lo_over_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) order_ok);
  // R2
  group_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~hi_q) == 32'(nlo_q));
  // R5
  shuffle_keeps_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shuffle_i && !quantum_end_i) |=> $stable(hi_q));
endmodule

// File: rtl/tcm_request_picker.sv
module tcm_request_picker #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned TID_W     = 2,
  parameter int unsigned AGE_W     = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] req_valid_i,
  input  logic [TID_W-1:0]     req_tid_i   [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] req_row_hit_i,
  input  logic [AGE_W-1:0]     req_age_i   [N_ENTRIES],
  input  logic [TID_W-1:0]     thread_rank_i [N_THREADS],
  output logic                 grant_valid_o,
  output logic [IDX_W-1:0]     grant_idx_o
);
  logic [TID_W-1:0] ent_rank [N_ENTRIES];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_rank
    assign ent_rank[e] = (32'(req_tid_i[e]) < N_THREADS) ? thread_rank_i[req_tid_i[e]] : '1;
  end

  function automatic logic beats(input logic [TID_W-1:0] ra, input logic ha,
                                 input logic [AGE_W-1:0] aa, input logic [TID_W-1:0] rb,
                                 input logic hb, input logic [AGE_W-1:0] ab);
    if (ra != rb) return ra < rb;
    if (ha != hb) return ha;
    return aa > ab;
  endfunction

  always_comb begin
    grant_valid_o = 1'b0;
    grant_idx_o   = '0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      if (req_valid_i[e] &&
          (!grant_valid_o ||
           beats(ent_rank[e], req_row_hit_i[e], req_age_i[e],
                 ent_rank[grant_idx_o], req_row_hit_i[grant_idx_o], req_age_i[grant_idx_o]))) begin
        grant_valid_o = 1'b1;
        grant_idx_o   = IDX_W'(e);
      end
    end
  end

  logic none_better;
  always_comb begin
    none_better = 1'b1;
    for (int e = 0; e < N_ENTRIES; e++) begin
      if (req_valid_i[e] && grant_valid_o) begin
        if (beats(ent_rank[e], req_row_hit_i[e], req_age_i[e],
                  ent_rank[grant_idx_o], req_row_hit_i[grant_idx_o], req_age_i[grant_idx_o]))
          none_better = 1'b0;
        if (IDX_W'(e) < grant_idx_o && ent_rank[e] == ent_rank[grant_idx_o] &&
            req_row_hit_i[e] == req_row_hit_i[grant_idx_o] &&
            req_age_i[e] == req_age_i[grant_idx_o])
          none_better = 1'b0;
      end
    end
  end

  // R6 R7 R8 R9
  best_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) none_better);
  // R9
  grant_is_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> req_valid_i[grant_idx_o]);
  // R10
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i == '0) |-> (!grant_valid_o && grant_idx_o == '0));
endmodule

// File: rtl/thread_cluster_arbiter.sv
module thread_cluster_arbiter
  import tcm_pkg::*;
#(
  parameter int unsigned N_THREADS   = 4,
  parameter int unsigned N_ENTRIES   = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned AGE_W       = 8,
  parameter int unsigned QUANTUM_LEN = 64,
  parameter int unsigned SHUFFLE_LEN = 8,
  localparam int unsigned TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ALPHA_W-1:0]         alpha_i,
  input  logic [N_THREADS-1:0]       miss_inc_i,
  input  logic [N_THREADS-1:0]       bw_inc_i,
  input  logic [N_ENTRIES-1:0]       req_valid_i,
  input  logic [N_ENTRIES*TID_W-1:0] req_tid_i,
  input  logic [N_ENTRIES-1:0]       req_row_hit_i,
  input  logic [N_ENTRIES*AGE_W-1:0] req_age_i,
  output logic                       grant_valid_o,
  output logic [IDX_W-1:0]           grant_idx_o,
  output logic [N_THREADS*TID_W-1:0] thread_rank_o,
  output logic [N_THREADS-1:0]       cluster_hi_o
);
  localparam int unsigned NLO_W = $clog2(N_THREADS + 1);

  logic             quantum_end, shuffle;
  logic [CNT_W-1:0] miss_cnt [N_THREADS];
  logic [CNT_W-1:0] bw_cnt   [N_THREADS];
  logic [TID_W-1:0] rank     [N_THREADS];
  logic [TID_W-1:0] tid      [N_ENTRIES];
  logic [AGE_W-1:0] age      [N_ENTRIES];

  tcm_epoch_timer #(.QUANTUM_LEN(QUANTUM_LEN), .SHUFFLE_LEN(SHUFFLE_LEN)) i_timer (
    .clk_i, .rst_ni, .quantum_end_o(quantum_end), .shuffle_o(shuffle)
  );

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thread
    tcm_thread_counter #(.CNT_W(CNT_W)) i_miss (
      .clk_i, .rst_ni, .clear_i(quantum_end), .inc_i(miss_inc_i[t]), .cnt_o(miss_cnt[t])
    );
    tcm_thread_counter #(.CNT_W(CNT_W)) i_bw (
      .clk_i, .rst_ni, .clear_i(quantum_end), .inc_i(bw_inc_i[t]), .cnt_o(bw_cnt[t])
    );
    assign thread_rank_o[t*TID_W +: TID_W] = rank[t];
  end

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    assign tid[e] = req_tid_i[e*TID_W +: TID_W];
    assign age[e] = req_age_i[e*AGE_W +: AGE_W];
  end

  tcm_rank_table #(
    .N_THREADS(N_THREADS), .CNT_W(CNT_W), .TID_W(TID_W), .NLO_W(NLO_W)
  ) i_ranks (
    .clk_i, .rst_ni, .alpha_i,
    .miss_cnt_i(miss_cnt), .bw_cnt_i(bw_cnt),
    .quantum_end_i(quantum_end), .shuffle_i(shuffle),
    .rank_o(rank), .hi_o(cluster_hi_o)
  );

  tcm_request_picker #(
    .N_ENTRIES(N_ENTRIES), .N_THREADS(N_THREADS), .TID_W(TID_W),
    .AGE_W(AGE_W), .IDX_W(IDX_W)
  ) i_pick (
    .clk_i, .rst_ni, .req_valid_i, .req_tid_i(tid), .req_row_hit_i,
    .req_age_i(age), .thread_rank_i(rank),
    .grant_valid_o, .grant_idx_o
  );
endmodule

// File: tb/test_thread_cluster_arbiter.sv
module test_thread_cluster_arbiter;
  localparam int NT = 4, NE = 8, TW = 2, AW = 8, IW = 3;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [5:0]     alpha = '0;
  logic [NT-1:0]  miss_inc = '0, bw_inc = '0;
  logic [NE-1:0]  req_valid = '0, req_hit = '0;
  logic [NE*TW-1:0] req_tid = '0;
  logic [NE*AW-1:0] req_age = '0;
  logic           grant_valid;
  logic [IW-1:0]  grant_idx;
  logic [NT*TW-1:0] ranks;
  logic [NT-1:0]  hi;

  int errors = 0, checks = 0, edge_cnt = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_ni) edge_cnt <= edge_cnt + 1;

  thread_cluster_arbiter #(
    .N_THREADS(NT), .N_ENTRIES(NE), .CNT_W(16), .AGE_W(AW),
    .QUANTUM_LEN(64), .SHUFFLE_LEN(8)
  ) i_thread_cluster_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .alpha_i(alpha),
    .miss_inc_i(miss_inc), .bw_inc_i(bw_inc),
    .req_valid_i(req_valid), .req_tid_i(req_tid), .req_row_hit_i(req_hit),
    .req_age_i(req_age), .grant_valid_o(grant_valid), .grant_idx_o(grant_idx),
    .thread_rank_o(ranks), .cluster_hi_o(hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ranks(input string req, input int r0, input int r1, input int r2,
                           input int r3, input int exp_hi);
    int exp_r;
    exp_r = r0 | (r1 << 2) | (r2 << 4) | (r3 << 6);
    chk({req, " ranks"}, int'(ranks), exp_r);
    chk({req, " groups"}, int'(hi), exp_hi);
  endtask

  task automatic wait_edge(input int n);
    while (edge_cnt < n) @(negedge clk);
  endtask

  task automatic clear_reqs();
    req_valid = '0; req_hit = '0; req_tid = '0; req_age = '0;
  endtask

  task automatic put(input int e, input int t, input bit h, input int a);
    req_valid[e] = 1'b1;
    req_hit[e]   = h;
    req_tid[e*TW +: TW] = TW'(t);
    req_age[e*AW +: AW] = AW'(a);
  endtask

  task automatic expect_grant(input string req, input int v, input int idx);
    #5;
    chk({req, " grant_valid"}, int'(grant_valid), v);
    chk({req, " grant_idx"}, int'(grant_idx), idx);
    @(negedge clk);
  endtask

  // identity ranks in quantum one: thread 0 best
  task automatic test_pick_basic();
    clear_reqs();
    expect_grant("R10 idle", 0, 0);
    clear_reqs(); put(5, 2, 1'b1, 250); put(3, 1, 1'b0, 0);
    expect_grant("R6 rank first", 1, 3);
    clear_reqs(); put(2, 1, 1'b0, 200); put(6, 1, 1'b1, 1);
    expect_grant("R7 row hit", 1, 6);
    clear_reqs(); put(1, 1, 1'b1, 5); put(4, 1, 1'b1, 9);
    expect_grant("R8 older", 1, 4);
    clear_reqs(); put(7, 2, 1'b1, 30); put(2, 2, 1'b1, 30);
    expect_grant("R9 tie low index", 1, 2);
    clear_reqs(); put(3, 3, 1'b0, 0); req_hit[0] = 1'b1; req_age[7:0] = 8'd255;
    expect_grant("R9 invalid ignored", 1, 3);
    clear_reqs();
  endtask

  task automatic drive_counts(input int m0, input int m1, input int m2, input int m3,
                              input int b0, input int b1, input int b2, input int b3);
    int m[4], b[4];
    m = '{m0, m1, m2, m3}; b = '{b0, b1, b2, b3};
    for (int c = 0; c < 40; c++) begin
      for (int t = 0; t < NT; t++) begin
        miss_inc[t] = (c < m[t]);
        bw_inc[t]   = (c < b[t]);
      end
      @(negedge clk);
    end
    miss_inc = '0; bw_inc = '0;
  endtask

  // alpha 6/64: threads 2,0 light; 1,3 heavy
  task automatic test_cluster_split();
    chk_ranks("R11 reset", 0, 1, 2, 3, 0);
    test_pick_basic();
    alpha = 6'd6;
    drive_counts(5, 20, 2, 40, 2, 10, 1, 30);
    wait_edge(63);
    chk_ranks("R3 no early update", 0, 1, 2, 3, 0);
    wait_edge(64);
    chk_ranks("R1 R2 R4 clustering", 1, 2, 0, 3, 4'b1010);
  endtask

  task automatic test_shuffle();
    wait_edge(72);
    chk_ranks("R5 first rotation", 1, 3, 0, 2, 4'b1010);
    clear_reqs(); put(1, 1, 1'b1, 200); put(4, 3, 1'b0, 1);
    expect_grant("R5 R6 rotated winner", 1, 4);
    wait_edge(80);
    chk_ranks("R5 second rotation", 1, 2, 0, 3, 4'b1010);
    expect_grant("R5 R6 rotated back", 1, 1);
    clear_reqs();
  endtask

  task automatic test_empty_quantum();
    wait_edge(128);
    chk_ranks("R3 counters restarted", 0, 1, 2, 3, 0);
  endtask

  // alpha 0: zero-bandwidth threads stay light; equal misses by index
  task automatic test_tie_zero_alpha();
    alpha = 6'd0;
    drive_counts(3, 1, 1, 0, 1, 0, 2, 0);
    wait_edge(192);
    chk_ranks("R1 R2 tie and zero share", 3, 1, 2, 0, 4'b0101);
    wait_edge(200);
    chk_ranks("R5 rotation two heavy", 2, 1, 3, 0, 4'b0101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    test_cluster_split();
    test_shuffle();
    test_empty_quantum();
    test_tie_zero_alpha();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule